// File: doc/BRIEF.md
# Exception Request Vectoring Unit

This unit sits beside the fetch and execute stages of a small RISC core. It gathers every exception request raised in a cycle, applies the enable masks, picks one winner by fixed priority and hands the core a handler offset together with a one-clock take strobe. The enable bits for machine checks and external interrupts are held here. Software sets them through write strobes, and the unit clears both whenever it takes an exception.

Reset requests (hard or soft) and machine checks are asynchronous in class and cannot be masked. The external interrupt is asynchronous but maskable. Its pin is level-sensitive and passes through a two-flop synchronizer. Page faults and alignment faults come from instructions and are precise. If a machine-check source fires while machine checks are disabled, the unit does not vector. It raises a sticky checkstop output, and after that only a reset request is honoured.

Top module: `exc_vector_unit`

## Requirements
- R1: While `rst_n` is low and right after its release, `take` is 0, `vec_offset` is 0x00100, `checkstop` is 0, and both `mc_enable` and `ext_enable` are 0.
- R2: A high `hard_rst_req` or `soft_rst_req` is taken with offset 0x00100 and clears `checkstop` at the same clock edge.
- R3: A high `bus_err_ack`, `mcheck_pin` or `dbl_bit_err` while `mc_enable` is 1 is taken with offset 0x00200.
- R4: A machine-check source while `mc_enable` is 0 sets `checkstop` instead of vectoring. `checkstop` then stays at 1 until a reset request or `rst_n` low.
- R5: While `checkstop` is set, or is being set in the current cycle, every request except reset is ignored.
- R6: An instruction page fault is taken with offset 0x00400, a data page fault with 0x00300 and an alignment fault with 0x00600.
- R7: The external interrupt (offset 0x00500) is taken only when `ext_enable` is 1 and the synchronized pin is high. A pin rising before clock edge k produces `take` after edge k+2.
- R8: If several requests are pending together, the winner is chosen in this order: reset, machine check, instruction page fault, data page fault, alignment, external interrupt.
- R9: `take` rises one edge after the winning request is sampled and lasts exactly one clock. The cycle right after a take never takes again. `vec_offset` changes only together with `take`.
- R10: A take clears `mc_enable` and `ext_enable` at the same edge and overrides a software write in that cycle. Otherwise a write strobe loads its value.
- R11: `vec_offset` is never 0x00000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hard_rst_req | input | 1 | Hard reset request |
| soft_rst_req | input | 1 | Soft reset request |
| bus_err_ack | input | 1 | Transfer error acknowledged on a bus transaction |
| mcheck_pin | input | 1 | Machine-check pin |
| dbl_bit_err | input | 1 | Double-bit address, data or cache error |
| dpage_fault | input | 1 | Data access page fault |
| ipage_fault | input | 1 | Instruction fetch page fault |
| ext_irq_pin | input | 1 | Level-sensitive external interrupt pin (asynchronous) |
| align_fault | input | 1 | Misaligned operand fault |
| mc_en_we | input | 1 | Software write strobe for the machine-check enable |
| mc_en_wdata | input | 1 | Value written to the machine-check enable |
| ext_en_we | input | 1 | Software write strobe for the external enable |
| ext_en_wdata | input | 1 | Value written to the external enable |
| vec_offset | output | VEC_W | Handler offset of the last taken exception |
| take | output | 1 | One-clock strobe: an exception is taken |
| checkstop | output | 1 | Sticky checkstop indication |
| mc_enable | output | 1 | Current machine-check enable |
| ext_enable | output | 1 | Current external interrupt enable |

## Verification
The properties assume that every request input except the external pin is synchronous to `clk`. They also assume that each fault source is a pulse its producer drops once the request has been seen, because a machine-check source still high after its own take finds the enable cleared and sets checkstop, as R4 requires. The bench changes every input on the falling clock edge and drives faults as single-cycle pulses. Reset requests are the exception: a few of them are held for several cycles on purpose, to exercise the forced gap of R9. The external pin is held for many cycles at a time, so the synchronizer always sees a settled level. In the random phase the fault pulses are sparse, and soft resets are added to clear the checkstops that the phase causes.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

  // Source indices; a lower index wins.
  localparam int SRC_RST   = 0;
  localparam int SRC_MC    = 1;
  localparam int SRC_IPF   = 2;
  localparam int SRC_DPF   = 3;
  localparam int SRC_ALIGN = 4;
  localparam int SRC_EXT   = 5;
  localparam int NUM_SRC   = 6;

  localparam logic [31:0] OFF_RST   = 32'h0000_0100;
  localparam logic [31:0] OFF_MC    = 32'h0000_0200;
  localparam logic [31:0] OFF_DPF   = 32'h0000_0300;
  localparam logic [31:0] OFF_IPF   = 32'h0000_0400;
  localparam logic [31:0] OFF_EXT   = 32'h0000_0500;
  localparam logic [31:0] OFF_ALIGN = 32'h0000_0600;

  function automatic logic [31:0] src_offset(input int idx);
    logic [31:0] off;
    case (idx)
      SRC_RST:   off = OFF_RST;
      SRC_MC:    off = OFF_MC;
      SRC_IPF:   off = OFF_IPF;
      SRC_DPF:   off = OFF_DPF;
      SRC_ALIGN: off = OFF_ALIGN;
      default:   off = OFF_EXT;
    endcase
    return off;
  endfunction

endpackage

// File: rtl/exc_sync.sv
module exc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] stage_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/exc_prio.sv
module exc_prio
  import exc_vec_pkg::*;
#(
  parameter int N     = NUM_SRC,
  parameter int VEC_W = 20
) (
  input  logic [N-1:0]     req,
  output logic             any_req,
  output logic [VEC_W-1:0] sel_offset
);

  logic [N-1:0]     higher;
  logic [N-1:0]     grant;
  logic [VEC_W-1:0] masked_off [N];

  generate
    for (genvar g = 0; g < N; g++) begin : g_src
      localparam logic [31:0] OFF_FULL = src_offset(g);
      if (g == 0) begin : g_top
        assign higher[0] = 1'b0;
      end else begin : g_rest
        assign higher[g] = higher[g-1] | req[g-1];
      end
      assign grant[g]      = req[g] & ~higher[g];
      assign masked_off[g] = grant[g] ? OFF_FULL[VEC_W-1:0] : '0;
    end
  endgenerate

  always_comb begin
    sel_offset = '0;
    for (int i = 0; i < N; i++) begin
      sel_offset = sel_offset | masked_off[i];
    end
  end

  assign any_req = |req;

endmodule

// File: rtl/exc_state.sv
module exc_state (
  input  logic clk,
  input  logic rst_n,
  input  logic take_d,
  input  logic rst_req,
  input  logic cstop_set,
  input  logic mc_en_we,
  input  logic mc_en_wdata,
  input  logic ext_en_we,
  input  logic ext_en_wdata,
  output logic mc_en_q,
  output logic ext_en_q,
  output logic cstop_q
);

  logic mc_en_d, ext_en_d, cstop_d;

  always_comb begin
    mc_en_d  = mc_en_q;
    ext_en_d = ext_en_q;
    cstop_d  = cstop_q;
    if (take_d) begin
      mc_en_d  = 1'b0;
      ext_en_d = 1'b0;
    end else begin
      if (mc_en_we)  mc_en_d  = mc_en_wdata;
      if (ext_en_we) ext_en_d = ext_en_wdata;
    end
    if (rst_req)        cstop_d = 1'b0;
    else if (cstop_set) cstop_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_en_q  <= 1'b0;
      ext_en_q <= 1'b0;
      cstop_q  <= 1'b0;
    end else begin
      mc_en_q  <= mc_en_d;
      ext_en_q <= ext_en_d;
      cstop_q  <= cstop_d;
    end
  end

endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_vec_pkg::*;
#(
  parameter int VEC_W       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hard_rst_req,
  input  logic             soft_rst_req,
  input  logic             bus_err_ack,
  input  logic             mcheck_pin,
  input  logic             dbl_bit_err,
  input  logic             dpage_fault,
  input  logic             ipage_fault,
  input  logic             ext_irq_pin,
  input  logic             align_fault,
  input  logic             mc_en_we,
  input  logic             mc_en_wdata,
  input  logic             ext_en_we,
  input  logic             ext_en_wdata,
  output logic [VEC_W-1:0] vec_offset,
  output logic             take,
  output logic             checkstop,
  output logic             mc_enable,
  output logic             ext_enable
);

  localparam logic [31:0] RST_FULL = OFF_RST;

  logic               ext_sync;
  logic               rst_req, mc_src, mc_ok, cstop_set, blocked;
  logic [NUM_SRC-1:0] req_raw, req_gated;
  logic               any_req;
  logic [VEC_W-1:0]   sel_offset;
  logic               take_d, take_q;
  logic [VEC_W-1:0]   vec_d, vec_q;
  logic               mc_en_q, ext_en_q, cstop_q;

  exc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (ext_irq_pin),
    .q_sync  (ext_sync)
  );

  always_comb begin
    rst_req   = hard_rst_req | soft_rst_req;
    mc_src    = bus_err_ack | mcheck_pin | dbl_bit_err;
    mc_ok     = mc_src & mc_en_q;
    cstop_set = mc_src & ~mc_en_q;
    blocked   = cstop_q | cstop_set;

    req_raw            = '0;
    req_raw[SRC_RST]   = rst_req;
    req_raw[SRC_MC]    = mc_ok & ~blocked;
    req_raw[SRC_IPF]   = ipage_fault & ~blocked;
    req_raw[SRC_DPF]   = dpage_fault & ~blocked;
    req_raw[SRC_ALIGN] = align_fault & ~blocked;
    req_raw[SRC_EXT]   = ext_sync & ext_en_q & ~blocked;

    req_gated = take_q ? '0 : req_raw;
  end

  exc_prio #(.N(NUM_SRC), .VEC_W(VEC_W)) u_prio (
    .req        (req_gated),
    .any_req    (any_req),
    .sel_offset (sel_offset)
  );

  always_comb begin
    take_d = any_req;
    vec_d  = any_req ? sel_offset : vec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      vec_q  <= RST_FULL[VEC_W-1:0];
    end else begin
      take_q <= take_d;
      vec_q  <= vec_d;
    end
  end

  exc_state u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .take_d       (take_d),
    .rst_req      (rst_req),
    .cstop_set    (cstop_set),
    .mc_en_we     (mc_en_we),
    .mc_en_wdata  (mc_en_wdata),
    .ext_en_we    (ext_en_we),
    .ext_en_wdata (ext_en_wdata),
    .mc_en_q      (mc_en_q),
    .ext_en_q     (ext_en_q),
    .cstop_q      (cstop_q)
  );

  assign vec_offset = vec_q;
  assign take       = take_q;
  assign checkstop  = cstop_q;
  assign mc_enable  = mc_en_q;
  assign ext_enable = ext_en_q;

endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk #(
  parameter int VEC_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hard_rst_req,
  input logic             soft_rst_req,
  input logic [VEC_W-1:0] vec_offset,
  input logic             take,
  input logic             checkstop,
  input logic             mc_enable,
  input logic             ext_enable
);

  localparam logic [VEC_W-1:0] V_RST = VEC_W'(32'h100);
  localparam logic [VEC_W-1:0] V_MC  = VEC_W'(32'h200);
  localparam logic [VEC_W-1:0] V_EXT = VEC_W'(32'h500);

  assert_take_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);

  assert_vec_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> $stable(vec_offset));

  assert_vec_nonzero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    vec_offset != '0);

  assert_cstop_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (checkstop && !hard_rst_req && !soft_rst_req) |=> checkstop);

  assert_cstop_only_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && $past(checkstop)) |-> (vec_offset == V_RST));

  assert_enables_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (!mc_enable && !ext_enable));

  assert_mc_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_offset == V_MC) |-> $past(mc_enable));

  assert_ext_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_offset == V_EXT) |-> $past(ext_enable));

endmodule

bind exc_vector_unit exc_vector_unit_chk #(.VEC_W(VEC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hard_rst_req (hard_rst_req),
  .soft_rst_req (soft_rst_req),
  .vec_offset   (vec_offset),
  .take         (take),
  .checkstop    (checkstop),
  .mc_enable    (mc_enable),
  .ext_enable   (ext_enable)
);

// File: tb/test_exc_vector_unit.sv
`timescale 1ns/1ps
module test_exc_vector_unit;

  localparam int VEC_W = 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic hard_rst_req, soft_rst_req, bus_err_ack, mcheck_pin, dbl_bit_err;
  logic dpage_fault, ipage_fault, ext_irq_pin, align_fault;
  logic mc_en_we, mc_en_wdata, ext_en_we, ext_en_wdata;
  logic [VEC_W-1:0] vec_offset;
  logic take, checkstop, mc_enable, ext_enable;

  exc_vector_unit #(.VEC_W(VEC_W), .SYNC_STAGES(2)) i_exc_vector_unit (
    .clk(clk), .rst_n(rst_n),
    .hard_rst_req(hard_rst_req), .soft_rst_req(soft_rst_req),
    .bus_err_ack(bus_err_ack), .mcheck_pin(mcheck_pin), .dbl_bit_err(dbl_bit_err),
    .dpage_fault(dpage_fault), .ipage_fault(ipage_fault),
    .ext_irq_pin(ext_irq_pin), .align_fault(align_fault),
    .mc_en_we(mc_en_we), .mc_en_wdata(mc_en_wdata),
    .ext_en_we(ext_en_we), .ext_en_wdata(ext_en_wdata),
    .vec_offset(vec_offset), .take(take), .checkstop(checkstop),
    .mc_enable(mc_enable), .ext_enable(ext_enable)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, updated at each rising edge.
  bit      m_take, m_mce, m_eie, m_chk;
  int      m_vec;
  bit      ext_pipe[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_take = 0; m_vec = 'h100; m_mce = 0; m_eie = 0; m_chk = 0;
      ext_pipe = '{1'b0, 1'b0};
    end else begin
      bit ext_now, rq, mcs, cs_new, blocked, t;
      int v;
      ext_now = ext_pipe.pop_front();
      ext_pipe.push_back(ext_irq_pin);
      rq      = hard_rst_req || soft_rst_req;
      mcs     = bus_err_ack || mcheck_pin || dbl_bit_err;
      cs_new  = mcs && !m_mce;
      blocked = m_chk || cs_new;
      t = 0; v = m_vec;
      if (!m_take) begin
        if (rq) begin t = 1; v = 'h100; end
        else if (!blocked) begin
          if (mcs)                      begin t = 1; v = 'h200; end
          else if (ipage_fault)         begin t = 1; v = 'h400; end
          else if (dpage_fault)         begin t = 1; v = 'h300; end
          else if (align_fault)         begin t = 1; v = 'h600; end
          else if (ext_now && m_eie)    begin t = 1; v = 'h500; end
        end
      end
      if (t) begin m_mce = 0; m_eie = 0; end
      else begin
        if (mc_en_we)  m_mce = mc_en_wdata;
        if (ext_en_we) m_eie = ext_en_wdata;
      end
      if (rq) m_chk = 0; else if (cs_new) m_chk = 1;
      m_take = t; m_vec = v;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R9 take vs model", take, m_take);
      check("R8 vector vs model", vec_offset, m_vec);
      check("R4 checkstop vs model", checkstop, m_chk);
      check("R10 mc_enable vs model", mc_enable, m_mce);
      check("R10 ext_enable vs model", ext_enable, m_eie);
      check("R11 vector nonzero", vec_offset != 0, 1);
    end
  end

  task automatic clear_inputs();
    hard_rst_req = 0; soft_rst_req = 0; bus_err_ack = 0; mcheck_pin = 0;
    dbl_bit_err = 0; dpage_fault = 0; ipage_fault = 0; ext_irq_pin = 0;
    align_fault = 0; mc_en_we = 0; mc_en_wdata = 0; ext_en_we = 0; ext_en_wdata = 0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0;
    clear_inputs();
    cyc(3);
    check("R1 take in reset", take, 0);
    check("R1 vector in reset", vec_offset, 'h100);
    rst_n = 1;
    cyc(1);
    check("R1 take after release", take, 0);
    check("R1 checkstop after release", checkstop, 0);
    check("R1 enables after release", {mc_enable, ext_enable}, 0);

    // R6 single faults
    ipage_fault = 1; cyc(1); ipage_fault = 0;
    check("R6 ipf take", take, 1); check("R6 ipf vector", vec_offset, 'h400);
    cyc(1);
    check("R9 strobe one cycle", take, 0); check("R9 vector held", vec_offset, 'h400);
    dpage_fault = 1; cyc(1); dpage_fault = 0;
    check("R6 dpf vector", vec_offset, 'h300);
    cyc(1);
    align_fault = 1; cyc(1); align_fault = 0;
    check("R6 align vector", vec_offset, 'h600);
    cyc(1);

    // R3 machine check with enable
    mc_en_we = 1; mc_en_wdata = 1; cyc(1); mc_en_we = 0;
    check("R10 mc_enable written", mc_enable, 1);
    mcheck_pin = 1; cyc(1); mcheck_pin = 0;
    check("R3 mc take", take, 1); check("R3 mc vector", vec_offset, 'h200);
    check("R10 mc_enable cleared by take", mc_enable, 0);
    cyc(1);

    // R8 priority
    mc_en_we = 1; mc_en_wdata = 1; ext_en_we = 1; ext_en_wdata = 1; cyc(1);
    mc_en_we = 0; ext_en_we = 0;
    dbl_bit_err = 1; ipage_fault = 1; dpage_fault = 1; align_fault = 1; cyc(1);
    dbl_bit_err = 0;
    check("R8 mc beats faults", vec_offset, 'h200);
    cyc(2);
    check("R8 ipf beats dpf", vec_offset, 'h400); ipage_fault = 0;
    cyc(2);
    check("R8 dpf beats align", vec_offset, 'h300); dpage_fault = 0;
    cyc(2);
    check("R8 align last", vec_offset, 'h600); align_fault = 0;
    cyc(2);

    // R7 external interrupt masked then enabled
    ext_irq_pin = 1; cyc(6);
    check("R7 masked ext no take", take, 0);
    ext_en_we = 1; ext_en_wdata = 1; cyc(1); ext_en_we = 0; cyc(1);
    check("R7 ext take", take, 1); check("R7 ext vector", vec_offset, 'h500);
    check("R10 ext_enable cleared", ext_enable, 0);
    cyc(4);
    check("R7 ext masked after take", take, 0);
    ext_irq_pin = 0; cyc(3);
    ext_en_we = 1; ext_en_wdata = 1; cyc(1); ext_en_we = 0;
    ext_irq_pin = 1; cyc(1);
    check("R7 sync latency edge1", take, 0); cyc(1);
    check("R7 sync latency edge2", take, 0); cyc(1);
    check("R7 sync latency edge3", take, 1);
    ext_irq_pin = 0; cyc(3);

    // R4/R5/R2 checkstop path (mc_enable is 0)
    bus_err_ack = 1; cyc(1); bus_err_ack = 0;
    check("R4 checkstop set", checkstop, 1); check("R4 no take", take, 0);
    ipage_fault = 1; cyc(1); ipage_fault = 0;
    check("R5 fault ignored in checkstop", take, 0);
    cyc(3);
    check("R4 checkstop sticky", checkstop, 1);
    soft_rst_req = 1; cyc(1); soft_rst_req = 0;
    check("R2 soft reset take", take, 1); check("R2 reset vector", vec_offset, 'h100);
    check("R2 checkstop cleared", checkstop, 0);
    cyc(2);

    // R10 take wins over same-cycle write
    ext_en_we = 1; ext_en_wdata = 1; ipage_fault = 1; cyc(1);
    ext_en_we = 0; ipage_fault = 0;
    check("R10 take overrides write", ext_enable, 0); check("R6 ipf again", vec_offset, 'h400);
    cyc(2);

    // R9 held hard reset: take, gap, take
    hard_rst_req = 1; cyc(1);
    check("R9 held reset first", take, 1); cyc(1);
    check("R9 held reset gap", take, 0); cyc(1);
    check("R9 held reset again", take, 1); hard_rst_req = 0; cyc(1);
    check("R9 after held reset", take, 0);
    cyc(2);

    // Random phase, compared against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      hard_rst_req = ($urandom_range(0, 199) == 0);
      soft_rst_req = ($urandom_range(0, 60) == 0);
      bus_err_ack  = ($urandom_range(0, 40) == 0);
      mcheck_pin   = ($urandom_range(0, 40) == 0);
      dbl_bit_err  = ($urandom_range(0, 40) == 0);
      ipage_fault  = ($urandom_range(0, 7) == 0);
      dpage_fault  = ($urandom_range(0, 7) == 0);
      align_fault  = ($urandom_range(0, 7) == 0);
      if ((i % 16) == 0) ext_irq_pin = $urandom_range(0, 1);
      mc_en_we     = ($urandom_range(0, 4) == 0);
      mc_en_wdata  = ($urandom_range(0, 3) != 0);
      ext_en_we    = ($urandom_range(0, 4) == 0);
      ext_en_wdata = $urandom_range(0, 1);
      cyc(1);
    end
    clear_inputs();
    cyc(5);
    finish_run();
  end

endmodule